// File: doc/BRIEF.md
# Start-Up Open-Circuit Voltage Capture and Restart Control

This block produces the first open-circuit voltage estimate of a battery cell when the gauge starts. An estimate is taken when reset is released, when software asks for a quick start, when the quick-start pin rises, or when the cell recovers from a voltage drop below a programmable floor. Each estimate opens a capture window. The window keeps the highest of the first sixteen 12-bit voltage samples it receives. Samples that come after the window has closed are ignored.

A millisecond time base is derived from the system clock. It sets two flags. The first marks the voltage estimate as ready 17 ms after a start. The second marks the initial charge result as ready 175 ms after that. The charge model itself is outside this block. The second flag only tells it when its input has settled.

The floor monitor compares each incoming sample with the programmed threshold. A dip below the threshold followed by a recovery starts a delay. When the delay expires, the block restarts. The delay is short while the fast comparator is in use and long while it is disabled. Every restart sets a sticky voltage-reset flag, and software clears that flag.

Top module: `ocv_startup_ctrl`

## Requirements
- R1: While reset is held and just after it is released, `ocv_ready` and `soc_ready` are 0, `vr_flag` is 1, `ocv_est` is 0 and `acq_open` is 1.
- R2: After a start, `ocv_est` holds the largest value among the first 16 valid samples. `acq_open` drops once 16 samples have been taken, and any later sample leaves `ocv_est` unchanged.
- R3: `ocv_ready` rises exactly 17·TICK_CYC clock edges after the edge that applies a start. From then on the window is closed and samples do not change `ocv_est`.
- R4: `soc_ready` rises exactly 175·TICK_CYC edges after `ocv_ready` rises. It stays high until the next start.
- R5: A one-cycle `qs_cmd` pulse applies a start at the next edge. The start clears `ocv_ready`, `soc_ready` and `ocv_est`, opens the window, and restarts the 17 ms timing. This holds in every phase, including after `soc_ready`.
- R6: A rising level on the asynchronous `qs_pin` applies a start at the third rising edge that sees the pin high. Holding the pin high, or letting it fall, causes no further start.
- R7: A valid sample below the floor arms the monitor, and a later sample at or above the floor begins a recovery delay. The floor in sample units is `thr_code`·32, so 1 code step is 40 mV and 1 sample step is 1.25 mV. With `cmp_dis`=0, a start is applied TICK_CYC edges (1 ms) after the recovery sample is taken. A sample at or above the floor without a prior dip does nothing.
- R8: With `cmp_dis`=1 when the recovery sample is taken, the recovery delay is 250·TICK_CYC edges.
- R9: A below-floor sample during the recovery delay cancels the delay and re-arms the monitor. No start follows until a new recovery sample arrives.
- R10: Every start sets `vr_flag` at the same edge. A `vr_clr` pulse clears it at the next edge unless a start is applied at that edge, in which case the flag stays set.
- R11: A start during an open window discards the samples already taken. The full count of 16 is then available again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| smp_vld | input | 1 | Voltage sample strobe |
| smp_data | input | 12 | Voltage sample, 1.25 mV per step |
| qs_pin | input | 1 | Asynchronous quick-start pin; its rising edge restarts |
| qs_cmd | input | 1 | One-cycle pulse: software wrote 1 to the quick-start bit |
| thr_code | input | 7 | Voltage floor, 40 mV per step |
| cmp_dis | input | 1 | 1 selects the slow recovery delay |
| vr_clr | input | 1 | One-cycle pulse clearing the voltage-reset flag |
| ocv_est | output | 12 | Peak-held open-circuit voltage estimate |
| ocv_ready | output | 1 | Voltage estimate ready |
| soc_ready | output | 1 | Initial charge result ready |
| acq_open | output | 1 | Capture window open and accepting samples |
| vr_flag | output | 1 | Sticky flag set by every restart |

## Verification
Each result falls due a fixed number of clock edges after its stimulus, counted from the edge that applies the start. `qs_cmd` takes effect 1 edge after its pulse and `qs_pin` 3 edges after it is first seen high. A floor restart follows the recovery sample by 4 edges, or by 1000 edges in slow mode. `ocv_ready` follows a start by 68 edges and `soc_ready` follows `ocv_ready` by 700 edges. The bench drives inputs and samples outputs on falling clock edges and keeps a running edge count in each scenario. For every timed result it checks one edge before the due edge, expecting the old value, and then at the due edge, expecting the new value.

// File: rtl/ocvs_pkg.sv
package ocvs_pkg;

  // Timing phase after a start
  typedef enum logic [1:0] {
    SEQ_ACQ    = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_DONE   = 2'd2
  } seq_state_t;

  // Floor monitor phase
  typedef enum logic [1:0] {
    MON_IDLE = 2'd0,
    MON_LOW  = 2'd1,
    MON_HOLD = 2'd2
  } mon_state_t;

endpackage

// File: rtl/ocvs_edge_sync.sv
module ocvs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise_o
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  assign sh_d[0] = pin_in;
  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    assign sh_d[g] = sh_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Rising level seen at the synchronized output
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/ocvs_peak.sv
module ocvs_peak #(
  parameter int SAMPLE_W = 12,
  parameter int BURST    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                win,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  output logic [SAMPLE_W-1:0] peak_o,
  output logic                open_o
);

  localparam int CNT_W = $clog2(BURST + 1);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SAMPLE_W-1:0] pk_q, pk_d;

  assign open_o = win && (cnt_q < BURST_C);

  always_comb begin
    cnt_d = cnt_q;
    pk_d  = pk_q;
    if (start) begin
      cnt_d = '0;
      pk_d  = '0;
    end else if (open_o && smp_vld) begin
      cnt_d = cnt_q + 1'b1;
      if (smp > pk_q) pk_d = smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pk_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      pk_q  <= pk_d;
    end
  end

  assign peak_o = pk_q;

endmodule

// File: rtl/ocvs_seq.sv
module ocvs_seq
  import ocvs_pkg::*;
#(
  parameter int TICK_CYC = 4,
  parameter int OCV_MS   = 17,
  parameter int SOC_MS   = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic win_o,
  output logic ocv_rdy_o,
  output logic soc_rdy_o
);

  localparam int DIV_W  = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int MS_MAX = (OCV_MS > SOC_MS) ? OCV_MS : SOC_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYC - 1);
  localparam logic [MS_W-1:0]  OCV_LAST = MS_W'(OCV_MS - 1);
  localparam logic [MS_W-1:0]  SOC_LAST = MS_W'(SOC_MS - 1);

  seq_state_t       st_q, st_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             ocv_q, ocv_d;
  logic             soc_q, soc_d;
  logic             tick;

  always_comb begin
    st_d  = st_q;
    div_d = div_q;
    ms_d  = ms_q;
    ocv_d = ocv_q;
    soc_d = soc_q;
    tick  = (div_q == DIV_LAST);
    if (start) begin
      st_d  = SEQ_ACQ;
      div_d = '0;
      ms_d  = '0;
      ocv_d = 1'b0;
      soc_d = 1'b0;
    end else if (st_q != SEQ_DONE) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (st_q == SEQ_ACQ) begin
          if (ms_q == OCV_LAST) begin
            ocv_d = 1'b1;
            st_d  = SEQ_SETTLE;
            ms_d  = '0;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end else begin
          if (ms_q == SOC_LAST) begin
            soc_d = 1'b1;
            st_d  = SEQ_DONE;
            ms_d  = '0;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_ACQ;
      div_q <= '0;
      ms_q  <= '0;
      ocv_q <= 1'b0;
      soc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      div_q <= div_d;
      ms_q  <= ms_d;
      ocv_q <= ocv_d;
      soc_q <= soc_d;
    end
  end

  assign win_o     = (st_q == SEQ_ACQ);
  assign ocv_rdy_o = ocv_q;
  assign soc_rdy_o = soc_q;

endmodule

// File: rtl/ocvs_swap_mon.sv
module ocvs_swap_mon
  import ocvs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int THR_W    = 7,
  parameter int TICK_CYC = 4,
  parameter int FAST_MS  = 1,
  parameter int SLOW_MS  = 250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [THR_W-1:0]    thr,
  input  logic                cmp_dis,
  output logic                fire_o
);

  localparam int SHIFT    = SAMPLE_W - THR_W;
  localparam int FAST_LIM = FAST_MS * TICK_CYC;
  localparam int SLOW_LIM = SLOW_MS * TICK_CYC;
  localparam int DLY_MAX  = (FAST_LIM > SLOW_LIM) ? FAST_LIM : SLOW_LIM;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam logic [DLY_W-1:0] FAST_END = DLY_W'(FAST_LIM - 1);
  localparam logic [DLY_W-1:0] SLOW_END = DLY_W'(SLOW_LIM - 1);

  mon_state_t          st_q, st_d;
  logic [DLY_W-1:0]    cnt_q, cnt_d;
  logic                slow_q, slow_d;
  logic [SAMPLE_W-1:0] floor_v;
  logic                below;
  logic [DLY_W-1:0]    end_sel;

  assign floor_v = {thr, {SHIFT{1'b0}}};
  assign below   = (smp < floor_v);
  assign end_sel = slow_q ? SLOW_END : FAST_END;
  assign fire_o  = (st_q == MON_HOLD) && (cnt_q == end_sel);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slow_d = slow_q;
    if (clr) begin
      st_d  = MON_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        MON_IDLE: if (smp_vld && below) st_d = MON_LOW;
        MON_LOW: begin
          if (smp_vld && !below) begin
            st_d   = MON_HOLD;
            cnt_d  = '0;
            slow_d = cmp_dis;
          end
        end
        MON_HOLD: begin
          if (smp_vld && below) begin
            st_d  = MON_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = MON_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MON_IDLE;
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
    end
  end

endmodule

// File: rtl/ocv_startup_ctrl.sv
module ocv_startup_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int THR_W    = 7,
  parameter int BURST    = 16,
  parameter int TICK_CYC = 4,
  parameter int OCV_MS   = 17,
  parameter int SOC_MS   = 175,
  parameter int FAST_MS  = 1,
  parameter int SLOW_MS  = 250,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                qs_pin,
  input  logic                qs_cmd,
  input  logic [THR_W-1:0]    thr_code,
  input  logic                cmp_dis,
  input  logic                vr_clr,
  output logic [SAMPLE_W-1:0] ocv_est,
  output logic                ocv_ready,
  output logic                soc_ready,
  output logic                acq_open,
  output logic                vr_flag
);

  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       pin_rise;
  logic       swap_fire;
  logic       restart;
  logic       win;
  logic       vr_q, vr_d;

  // Reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  ocvs_edge_sync #(.STAGES(SYNC_STG)) u_pin (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pin_in (qs_pin),
    .rise_o (pin_rise)
  );

  ocvs_swap_mon #(
    .SAMPLE_W (SAMPLE_W),
    .THR_W    (THR_W),
    .TICK_CYC (TICK_CYC),
    .FAST_MS  (FAST_MS),
    .SLOW_MS  (SLOW_MS)
  ) u_mon (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (restart),
    .smp_vld (smp_vld),
    .smp     (smp_data),
    .thr     (thr_code),
    .cmp_dis (cmp_dis),
    .fire_o  (swap_fire)
  );

  assign restart = qs_cmd | pin_rise | swap_fire;

  ocvs_seq #(
    .TICK_CYC (TICK_CYC),
    .OCV_MS   (OCV_MS),
    .SOC_MS   (SOC_MS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (restart),
    .win_o     (win),
    .ocv_rdy_o (ocv_ready),
    .soc_rdy_o (soc_ready)
  );

  ocvs_peak #(
    .SAMPLE_W (SAMPLE_W),
    .BURST    (BURST)
  ) u_peak (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (restart),
    .win     (win),
    .smp_vld (smp_vld),
    .smp     (smp_data),
    .peak_o  (ocv_est),
    .open_o  (acq_open)
  );

  always_comb begin
    vr_d = vr_q;
    if (restart)     vr_d = 1'b1;
    else if (vr_clr) vr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vr_q <= 1'b1;
    else            vr_q <= vr_d;
  end

  assign vr_flag = vr_q;

endmodule

// File: rtl/ocvs_chk.sv
module ocvs_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst_int_n,
  input logic                restart,
  input logic                vr_clr,
  input logic [SAMPLE_W-1:0] ocv_est,
  input logic                ocv_ready,
  input logic                soc_ready,
  input logic                acq_open,
  input logic                vr_flag
);

  // R4
  ready_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    soc_ready |-> ocv_ready);

  // R3
  win_closed_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ocv_ready |-> !acq_open);

  // R2
  peak_rise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && !$past(restart) && $past(acq_open)) |-> (ocv_est >= $past(ocv_est)));

  // R2
  peak_frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && !$past(restart) && !$past(acq_open)) |-> $stable(ocv_est));

  // R5
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && $past(restart)) |-> (!ocv_ready && !soc_ready && ocv_est == '0 && acq_open));

  // R10
  vr_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && $past(restart)) |-> vr_flag);

  // R10
  vr_clr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && $past(vr_clr) && !$past(restart)) |-> !vr_flag);

  // R4
  soc_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(rst_int_n) && $past(soc_ready) && !$past(restart)) |-> soc_ready);

endmodule

bind ocv_startup_ctrl ocvs_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .restart   (restart),
  .vr_clr    (vr_clr),
  .ocv_est   (ocv_est),
  .ocv_ready (ocv_ready),
  .soc_ready (soc_ready),
  .acq_open  (acq_open),
  .vr_flag   (vr_flag)
);

// File: tb/sim_ocv_startup_ctrl.sv
module sim_ocv_startup_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 4;
  localparam int OCV_EDGES  = 17 * TICK;
  localparam int SOC_EDGES  = 175 * TICK;
  localparam int FAST_EDGES = 1 * TICK;
  localparam int SLOW_EDGES = 250 * TICK;
  localparam int WDOG       = 100000;

  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [11:0] smp_data;
  logic        qs_pin;
  logic        qs_cmd;
  logic [6:0]  thr_code;
  logic        cmp_dis;
  logic        vr_clr;
  logic [11:0] ocv_est;
  logic        ocv_ready;
  logic        soc_ready;
  logic        acq_open;
  logic        vr_flag;

  int total = 0;
  int bad   = 0;

  ocv_startup_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .qs_pin    (qs_pin),
    .qs_cmd    (qs_cmd),
    .thr_code  (thr_code),
    .cmp_dis   (cmp_dis),
    .vr_clr    (vr_clr),
    .ocv_est   (ocv_est),
    .ocv_ready (ocv_ready),
    .soc_ready (soc_ready),
    .acq_open  (acq_open),
    .vr_flag   (vr_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_qs();
    qs_cmd = 1'b1;
    @(negedge clk);
    qs_cmd = 1'b0;
  endtask

  task automatic pulse_clr();
    vr_clr = 1'b1;
    @(negedge clk);
    vr_clr = 1'b0;
  endtask

  task automatic send(input int v);
    smp_vld  = 1'b1;
    smp_data = 12'(v);
    @(negedge clk);
    smp_vld  = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ocv_ready in reset", int'(ocv_ready), 0);
    chk("R1", "vr_flag in reset", int'(vr_flag), 1);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1", "ocv_ready", int'(ocv_ready), 0);
    chk("R1", "soc_ready", int'(soc_ready), 0);
    chk("R1", "vr_flag", int'(vr_flag), 1);
    chk("R1", "ocv_est", int'(ocv_est), 0);
    chk("R1", "acq_open", int'(acq_open), 1);
  endtask

  task automatic t_peak();
    pulse_qs();
    for (int i = 0; i < 16; i++) send((i == 7) ? 12'hABC : (i * 37 + 100));
    chk("R2", "window closes after 16", int'(acq_open), 0);
    send(12'hFFF);
    chk("R2", "peak ignores 17th", int'(ocv_est), 12'hABC);
    wait_n(OCV_EDGES - 1 - 17);
    chk("R3", "ocv_ready one edge early", int'(ocv_ready), 0);
    wait_n(1);
    chk("R3", "ocv_ready due", int'(ocv_ready), 1);
    send(12'hFFF);
    chk("R3", "closed window ignores sample", int'(ocv_est), 12'hABC);
    wait_n(SOC_EDGES - 2);
    chk("R4", "soc_ready one edge early", int'(soc_ready), 0);
    wait_n(1);
    chk("R4", "soc_ready due", int'(soc_ready), 1);
    wait_n(10);
    chk("R4", "soc_ready holds", int'(soc_ready), 1);
  endtask

  task automatic t_restart();
    pulse_qs();
    chk("R5", "ocv_ready cleared", int'(ocv_ready), 0);
    chk("R5", "soc_ready cleared", int'(soc_ready), 0);
    chk("R5", "ocv_est cleared", int'(ocv_est), 0);
    chk("R5", "window reopened", int'(acq_open), 1);
    send(12'hF00);
    for (int i = 0; i < 4; i++) send(12'h050 + i);
    pulse_qs();
    chk("R11", "peak dropped on restart", int'(ocv_est), 0);
    chk("R11", "window open", int'(acq_open), 1);
    for (int i = 0; i < 16; i++) send(12'h100 + i);
    chk("R11", "full 16 accepted", int'(ocv_est), 12'h10F);
    send(12'hFFF);
    chk("R11", "17th ignored", int'(ocv_est), 12'h10F);
    wait_n(OCV_EDGES - 1 - 17);
    chk("R5", "timing restarted, early", int'(ocv_ready), 0);
    wait_n(1);
    chk("R5", "timing restarted, due", int'(ocv_ready), 1);
  endtask

  task automatic t_vr();
    pulse_clr();
    chk("R10", "vr_flag cleared", int'(vr_flag), 0);
    qs_cmd = 1'b1;
    vr_clr = 1'b1;
    @(negedge clk);
    qs_cmd = 1'b0;
    vr_clr = 1'b0;
    chk("R10", "restart beats clear", int'(vr_flag), 1);
    pulse_clr();
    chk("R10", "vr_flag cleared again", int'(vr_flag), 0);
  endtask

  task automatic t_pin();
    pulse_qs();
    pulse_clr();
    send(12'h200);
    qs_pin = 1'b1;
    wait_n(1);
    chk("R6", "no start at 1st edge", int'(ocv_est), 12'h200);
    wait_n(1);
    chk("R6", "no start at 2nd edge", int'(vr_flag), 0);
    wait_n(1);
    chk("R6", "start at 3rd edge est", int'(ocv_est), 0);
    chk("R6", "start at 3rd edge vr", int'(vr_flag), 1);
    send(12'h300);
    wait_n(5);
    chk("R6", "held pin no retrigger", int'(ocv_est), 12'h300);
    qs_pin = 1'b0;
    wait_n(4);
    chk("R6", "falling pin no start", int'(ocv_est), 12'h300);
  endtask

  task automatic t_swap_fast();
    thr_code = 7'd80;
    cmp_dis  = 1'b0;
    pulse_qs();
    pulse_clr();
    send(3000);
    wait_n(10);
    chk("R7", "above floor without dip", int'(vr_flag), 0);
    send(2559);
    send(2560);
    wait_n(FAST_EDGES - 1);
    chk("R7", "fast delay early", int'(vr_flag), 0);
    wait_n(1);
    chk("R7", "fast restart vr", int'(vr_flag), 1);
    chk("R7", "fast restart est", int'(ocv_est), 0);
    pulse_clr();
    send(2559);
    send(2560);
    send(2559);
    wait_n(8);
    chk("R9", "dip during delay cancels", int'(vr_flag), 0);
    send(2600);
    wait_n(FAST_EDGES - 1);
    chk("R9", "re-armed, early", int'(vr_flag), 0);
    wait_n(1);
    chk("R9", "re-armed restart", int'(vr_flag), 1);
  endtask

  task automatic t_swap_slow();
    cmp_dis = 1'b1;
    pulse_clr();
    send(2559);
    send(2560);
    wait_n(SLOW_EDGES - 1);
    chk("R8", "slow delay early", int'(vr_flag), 0);
    wait_n(1);
    chk("R8", "slow restart", int'(vr_flag), 1);
    cmp_dis  = 1'b0;
    thr_code = 7'd0;
  endtask

  initial begin
    rst_n    = 1'b0;
    smp_vld  = 1'b0;
    smp_data = '0;
    qs_pin   = 1'b0;
    qs_cmd   = 1'b0;
    thr_code = 7'd0;
    cmp_dis  = 1'b0;
    vr_clr   = 1'b0;
    wait_n(3);
    t_reset();
    t_peak();
    t_restart();
    t_vr();
    t_pin();
    t_swap_fast();
    t_swap_slow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", WDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule